// File: doc/BRIEF.md
# Control Register Store and Trap Unit

This execution unit sits beside the integer datapath of a small 32-bit processor. It handles one group of 16-bit instructions. Some copy a system, banked or multiply/procedure register into a general register. Others push one of those registers to memory through a pre-decremented pointer. The last is a software trap, which records the return state and jumps to a handler at a fixed distance above the vector base.

The issuing stage presents an opcode with `op_valid` while `busy` is low. The unit reads the pointer register through the general register read port, using the opcode's register field. It drives the register write port, a 32-bit memory write port with a ready handshake, and the save and jump strobes for the trap. `done` pulses once when a legal instruction completes. An opcode outside the group raises `illegal` for one cycle instead.

Top module: `ctl_store_trap`

## Requirements
- R1: After reset, `busy`, `done`, `illegal`, `gpr_we`, `mem_req`, `trap_save` and `pc_we` are all low.
- R2: Opcode 0000nnnn1bbb0010 writes banked register b (`bank_regs[b*32+:32]`) into Rn. This happens in the cycle after acceptance, together with `done`.
- R3: Opcode 0000nnnn00ss1010 writes a register into Rn in the cycle after acceptance, together with `done`. The selector ss picks MACH (00), MACL (01) or PR (10).
- R4: Opcode 0100nnnnssss0011 pushes a register to memory. The selector ssss picks SR=0000, GBR=0001, VBR=0010, SSR=0011, SPC=0100 or banked register ssss[2:0] for 1ssss. The write goes to address Rn-4. When the write completes, Rn receives Rn-4 and `done` pulses.
- R5: Opcode 0100nnnn00ss0010 pushes MACH, MACL or PR (selector as in R3) to Rn-4, with the same pointer update as R4.
- R6: While `mem_req` is high and `mem_ready` is low, the request stays asserted with a stable address and data. During this stall there is no `done` and no register write.
- R7: Trap opcode 11000011iiiiiiii pulses `trap_save` in the cycle after acceptance. In that cycle `spc_wdata` equals PC, `ssr_wdata` equals SR, and `tra_wdata` equals the immediate shifted left by 2.
- R8: A trap keeps `busy` high for TRAP_STATES cycles. In the last of them it pulses `pc_we` with `pc_wdata` = VBR + 0x100, together with `done`.
- R9: `done` pulses exactly once for each legal instruction, and only while `busy` is high. `busy` falls in the cycle after `done`.
- R10: Any other opcode pulses `illegal` for one cycle. It causes no register write, no memory request, no trap strobe and no `done`.
- R11: `op_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Opcode present |
| op_code | input | 16 | Instruction word |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction complete pulse |
| illegal | output | 1 | Opcode not in this group |
| gpr_raddr | output | 4 | General register read index |
| gpr_rdata | input | 32 | General register read value |
| gpr_we | output | 1 | General register write enable |
| gpr_waddr | output | 4 | General register write index |
| gpr_wdata | output | 32 | General register write value |
| pc | input | 32 | Current program counter |
| sr | input | 32 | Status register |
| gbr | input | 32 | Global base register |
| vbr | input | 32 | Vector base register |
| ssr | input | 32 | Saved status register |
| spc | input | 32 | Saved program counter |
| mach | input | 32 | Multiply high |
| macl | input | 32 | Multiply low |
| pr | input | 32 | Procedure return register |
| bank_regs | input | 256 | Eight banked registers, b at [b*32+:32] |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Word to store |
| mem_ready | input | 1 | Memory accepts the write |
| trap_save | output | 1 | Strobe to write SPC, SSR and TRA |
| spc_wdata | output | 32 | Value for SPC |
| ssr_wdata | output | 32 | Value for SSR |
| tra_wdata | output | 32 | Value for TRA |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | 32 | Trap vector target |

## Verification
The stimulus draws random opcodes from each legal class: banked copy, MACH/MACL/PR copy, control and banked push, MACH/MACL/PR push, and trap. Each draw uses fresh random register contents, so a wrong selector field returns the wrong value instead of an equal one. Pushes run with 0 to 3 stall cycles. This separates a write that waits for `mem_ready` from one that completes early, and a pointer that is decremented once from one that is not. Random words that fall outside the group probe the decode edges, for example the unused selectors 0101–0111 and 0011 in the push and copy forms. An opcode offered during a trap shows whether a busy unit takes new work.

// File: rtl/ctl_store_trap.sv
module ctl_store_trap #(
  parameter int          TRAP_STATES = 8,
  parameter logic [31:0] VEC_OFFSET  = 32'h100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [15:0]  op_code,
  output logic         busy,
  output logic         done,
  output logic         illegal,
  output logic [3:0]   gpr_raddr,
  input  logic [31:0]  gpr_rdata,
  output logic         gpr_we,
  output logic [3:0]   gpr_waddr,
  output logic [31:0]  gpr_wdata,
  input  logic [31:0]  pc,
  input  logic [31:0]  sr,
  input  logic [31:0]  gbr,
  input  logic [31:0]  vbr,
  input  logic [31:0]  ssr,
  input  logic [31:0]  spc,
  input  logic [31:0]  mach,
  input  logic [31:0]  macl,
  input  logic [31:0]  pr,
  input  logic [255:0] bank_regs,
  output logic         mem_req,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic         mem_ready,
  output logic         trap_save,
  output logic [31:0]  spc_wdata,
  output logic [31:0]  ssr_wdata,
  output logic [31:0]  tra_wdata,
  output logic         pc_we,
  output logic [31:0]  pc_wdata
);
  localparam int CW = (TRAP_STATES > 2) ? $clog2(TRAP_STATES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TRAP_STATES - 1);

  typedef enum logic [2:0] {S_IDLE, S_COPY, S_PUSH, S_TRAP, S_ILL} state_t;
  state_t state;

  logic [3:0]  n_q;
  logic [31:0] val_q, addr_q, tpc_q, tsr_q;
  logic [7:0]  imm_q;
  logic [CW-1:0] cnt;

  wire [3:0] grp = op_code[15:12];
  wire [3:0] sel = op_code[7:4];
  wire [3:0] sfx = op_code[3:0];

  wire is_cbank = grp == 4'h0 && sel[3] && sfx == 4'h2;
  wire is_cmac  = grp == 4'h0 && sel < 4'd3 && sfx == 4'hA;
  wire is_pctl  = grp == 4'h4 && sfx == 4'h3 && (sel < 4'd5 || sel[3]);
  wire is_pmac  = grp == 4'h4 && sfx == 4'h2 && sel < 4'd3;
  wire is_trap  = op_code[15:8] == 8'hC3;

  logic [31:0] ctl_val, mac_val;
  always_comb begin
    case (sel)
      4'd0:    ctl_val = sr;
      4'd1:    ctl_val = gbr;
      4'd2:    ctl_val = vbr;
      4'd3:    ctl_val = ssr;
      4'd4:    ctl_val = spc;
      default: ctl_val = bank_regs[sel[2:0]*32 +: 32];
    endcase
    case (sel[1:0])
      2'd0:    mac_val = mach;
      2'd1:    mac_val = macl;
      default: mac_val = pr;
    endcase
  end

  wire [31:0] sel_val = (is_cmac || is_pmac) ? mac_val : ctl_val;
  wire        accept  = op_valid && state == S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      n_q <= '0; val_q <= '0; addr_q <= '0;
      tpc_q <= '0; tsr_q <= '0; imm_q <= '0; cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          n_q    <= op_code[11:8];
          val_q  <= is_trap ? vbr + VEC_OFFSET : sel_val;
          addr_q <= gpr_rdata - 32'd4;
          tpc_q  <= pc;
          tsr_q  <= sr;
          imm_q  <= op_code[7:0];
          cnt    <= '0;
          if (is_cbank || is_cmac)      state <= S_COPY;
          else if (is_pctl || is_pmac)  state <= S_PUSH;
          else if (is_trap)             state <= S_TRAP;
          else                          state <= S_ILL;
        end
        S_PUSH: if (mem_ready) state <= S_IDLE;
        S_TRAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire push_end = state == S_PUSH && mem_ready;
  wire trap_end = state == S_TRAP && cnt == LAST;

  assign busy      = state != S_IDLE && state != S_ILL;
  assign illegal   = state == S_ILL;
  assign done      = state == S_COPY || push_end || trap_end;
  assign gpr_raddr = op_code[11:8];
  assign gpr_we    = state == S_COPY || push_end;
  assign gpr_waddr = n_q;
  assign gpr_wdata = state == S_PUSH ? addr_q : val_q;
  assign mem_req   = state == S_PUSH;
  assign mem_addr  = addr_q;
  assign mem_wdata = val_q;
  assign trap_save = state == S_TRAP && cnt == '0;
  assign spc_wdata = tpc_q;
  assign ssr_wdata = tsr_q;
  assign tra_wdata = {22'd0, imm_q, 2'b00};
  assign pc_we     = trap_end;
  assign pc_wdata  = val_q;

  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_busy_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));
  assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |-> !done && !gpr_we);
  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !gpr_we && !mem_req && !trap_save && !pc_we && !done);
  assert_save_then_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_save |=> busy && !trap_save);
  assert_jump_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> done && !gpr_we);
endmodule

// File: tb/ctl_store_trap_test.sv
`timescale 1ns/100ps
module ctl_store_trap_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        op_valid = 0, mem_ready = 0;
  logic [15:0] op_code = 0;
  logic [31:0] gpr_rdata = 0, pc = 0, sr = 0, gbr = 0, vbr = 0, ssr = 0, spc = 0;
  logic [31:0] mach = 0, macl = 0, pr = 0;
  logic [31:0] bank [8];
  logic [255:0] bank_flat;
  for (genvar g = 0; g < 8; g++) begin : g_bank
    assign bank_flat[g*32 +: 32] = bank[g];
  end

  logic busy, done, illegal, gpr_we, mem_req, trap_save, pc_we;
  logic [3:0] gpr_raddr, gpr_waddr;
  logic [31:0] gpr_wdata, mem_addr, mem_wdata, spc_wdata, ssr_wdata, tra_wdata, pc_wdata;

  ctl_store_trap uut (
    .clk, .rst_n, .op_valid, .op_code, .busy, .done, .illegal,
    .gpr_raddr, .gpr_rdata, .gpr_we, .gpr_waddr, .gpr_wdata,
    .pc, .sr, .gbr, .vbr, .ssr, .spc, .mach, .macl, .pr, .bank_regs(bank_flat),
    .mem_req, .mem_addr, .mem_wdata, .mem_ready,
    .trap_save, .spc_wdata, .ssr_wdata, .tra_wdata, .pc_we, .pc_wdata);

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit legal(input logic [15:0] o);
    if (o[15:8] == 8'hC3) return 1;
    if (o[15:12] == 0 && o[7] && o[3:0] == 4'h2) return 1;
    if (o[15:12] == 0 && o[7:4] < 3 && o[3:0] == 4'hA) return 1;
    if (o[15:12] == 4 && o[3:0] == 4'h3 && (o[7:4] < 5 || o[7])) return 1;
    if (o[15:12] == 4 && o[3:0] == 4'h2 && o[7:4] < 3) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model(input logic [15:0] o);
    logic [3:0] s = o[7:4];
    if (o[3:0] == 4'hA || (o[15:12] == 4 && o[3:0] == 4'h2))
      return s == 0 ? mach : s == 1 ? macl : pr;
    if (s[3]) return bank[s[2:0]];
    case (s)
      0: return sr;
      1: return gbr;
      2: return vbr;
      3: return ssr;
      default: return spc;
    endcase
  endfunction

  task automatic scramble();
    pc = $urandom; sr = $urandom; gbr = $urandom; vbr = $urandom & 32'hFFFF_FC00;
    ssr = $urandom; spc = $urandom; mach = $urandom; macl = $urandom; pr = $urandom;
    gpr_rdata = $urandom & 32'hFFFF_FFFC;
    for (int i = 0; i < 8; i++) bank[i] = $urandom;
  endtask

  task automatic issue(input logic [15:0] o);
    @(negedge clk);
    scramble();
    op_code = o; op_valid = 1;
  endtask

  task automatic run_copy(input logic [15:0] o, input string tag);
    logic [31:0] e;
    issue(o);
    e = model(o);
    @(negedge clk); op_valid = 0; #0.5;
    chk(gpr_we && done && busy, tag, {gpr_we, done, busy}, 3'b111);
    chk(gpr_waddr == o[11:8], tag, gpr_waddr, o[11:8]);
    chk(gpr_wdata == e, tag, gpr_wdata, e);
    @(negedge clk); #0.5;
    chk(!busy && !done && !gpr_we, "R9", {busy, done, gpr_we}, 0);
  endtask

  task automatic run_push(input logic [15:0] o, input string tag);
    logic [31:0] e, a;
    int k;
    k = $urandom % 4;
    issue(o);
    e = model(o); a = gpr_rdata - 4;
    @(negedge clk); op_valid = 0; mem_ready = 0; #0.5;
    for (int j = 0; j < k; j++) begin
      chk(mem_req && mem_addr == a && mem_wdata == e, "R6", mem_addr, a);
      chk(!done && !gpr_we, "R6", {done, gpr_we}, 0);
      @(negedge clk); #0.5;
    end
    mem_ready = 1; #0.5;
    chk(mem_req && mem_addr == a, tag, mem_addr, a);
    chk(mem_wdata == e, tag, mem_wdata, e);
    chk(done && gpr_we && gpr_waddr == o[11:8] && gpr_wdata == a, tag, gpr_wdata, a);
    @(negedge clk); mem_ready = 0; #0.5;
    chk(!busy && !mem_req && !done, "R9", {busy, mem_req, done}, 0);
  endtask

  task automatic run_trap(input logic [15:0] o, input bit poke);
    logic [31:0] epc, esr, ev;
    issue(o);
    epc = pc; esr = sr; ev = vbr + 32'h100;
    @(negedge clk); op_valid = 0; #0.5;
    chk(trap_save && spc_wdata == epc && ssr_wdata == esr, "R7", spc_wdata, epc);
    chk(tra_wdata == {22'd0, o[7:0], 2'b00}, "R7", tra_wdata, {22'd0, o[7:0], 2'b00});
    for (int i = 0; i < 8; i++) begin
      chk(busy, "R8", busy, 1);
      chk(pc_we == (i == 7) && done == (i == 7), "R9", {pc_we, done}, {2{i == 7}});
      if (i > 0) chk(!trap_save, "R7", trap_save, 0);
      if (i == 7) chk(pc_wdata == ev, "R8", pc_wdata, ev);
      if (poke && i == 3) begin op_code = 16'h0582; op_valid = 1; end
      @(negedge clk); op_valid = 0; #0.5;
    end
    chk(!busy && !gpr_we && !done, poke ? "R11" : "R8", {busy, gpr_we, done}, 0);
  endtask

  task automatic run_bad(input logic [15:0] o);
    issue(o);
    @(negedge clk); op_valid = 0; #0.5;
    chk(illegal, "R10", illegal, 1);
    chk(!gpr_we && !mem_req && !trap_save && !pc_we && !done, "R10",
        {gpr_we, mem_req, trap_save, pc_we, done}, 0);
    @(negedge clk); #0.5;
    chk(!illegal && !busy && !gpr_we, "R10", {illegal, busy, gpr_we}, 0);
  endtask

  function automatic logic [15:0] rnd_op(input int cls);
    logic [3:0] n = 4'($urandom);
    logic [2:0] b = 3'($urandom);
    logic [1:0] m = 2'($urandom % 3);
    logic [3:0] c;
    logic [15:0] o;
    case (cls)
      0: return {4'h0, n, 1'b1, b, 4'h2};
      1: return {4'h0, n, 2'b00, m, 4'hA};
      2: begin c = ($urandom % 2) ? {1'b1, b} : 4'($urandom % 5); return {4'h4, n, c, 4'h3}; end
      3: return {4'h4, n, 2'b00, m, 4'h2};
      4: return {8'hC3, 8'($urandom)};
      default: begin
        do o = 16'($urandom); while (legal(o));
        return o;
      end
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    scramble();
    #1;
    chk(!busy && !done && !illegal && !gpr_we && !mem_req && !trap_save && !pc_we,
        "R1", {busy, done, illegal, gpr_we, mem_req, trap_save, pc_we}, 0);
    #10 rst_n = 1;
    @(negedge clk); #0.5;
    chk(!busy && !done && !mem_req, "R1", {busy, done, mem_req}, 0);

    run_copy(16'h0F82, "R2");
    run_copy(16'h03F2, "R2");
    run_copy(16'h022A, "R3");
    run_push(16'h4F03, "R4");
    run_push(16'h4143, "R4");
    run_push(16'h45F3, "R4");
    run_push(16'h4222, "R5");
    run_trap(16'hC3FF, 0);
    run_trap(16'hC300, 1);
    run_bad(16'h4053);
    run_bad(16'h4073);
    run_bad(16'h003A);
    run_bad(16'h4032);
    run_bad(16'h0072);
    run_bad(16'hC203);

    for (int t = 0; t < 300; t++) begin
      int cls = $urandom % 6;
      logic [15:0] o = rnd_op(cls);
      case (cls)
        0: run_copy(o, "R2");
        1: run_copy(o, "R3");
        2: run_push(o, "R4");
        3: run_push(o, "R5");
        4: run_trap(o, ($urandom % 4) == 0);
        default: run_bad(o);
      endcase
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule